// File: doc/BRIEF.md
# Packet Receive Deframer

This block sits behind the sync-word correlator of a packet radio receiver. Once sync is found it turns the recovered serial chip stream into payload bytes and hands them to a receive FIFO through a write port. It can first undo a DC-free line code, either Manchester or a 9-bit whitening sequence. It then applies three filters: a maximum packet length, an optional address match and an optional 16-bit CRC check. The result is reported through two single-cycle interrupt pulses, or the packet is discarded by pulsing the FIFO clear.

Every byte the deframer keeps is written to the FIFO as received, MSB first. This includes the length byte and the address byte. The CRC bytes are consumed but never written. The block does not start a new packet while the FIFO still holds data, so a host that reads out one payload cannot have it overwritten by the next.

Top module: `rxd_deframer`

## Requirements
- R1: Chips that arrive while no packet is open are dropped, including the chip presented in the same cycle as `sync_found`. Capture begins with the first chip strobed after that cycle.
- R2: Decoded bits are packed MSB first into bytes. Every kept byte, including the length and address bytes, appears on `fifo_wdata` with a one-cycle `fifo_wr` pulse. A write and a clear never occur in the same cycle.
- R3: `cfg_line` selects the line code. The codes are:
  - 0: plain chips.
  - 1: Manchester. Chips are taken in pairs from the first chip after sync, and the pair "1,0" means 1 while "0,1" means 0.
  - 2: whitening. Each data bit is the chip XOR bit 0 of a 9-bit register seeded to all ones. After each chip the register shifts right and takes (bit 0 XOR bit 5) into bit 8.
- R4: Length filtering works as follows:
  - With `cfg_var_len` = 1, the first byte is a length L that counts the bytes after it, the address included.
  - The packet is kept only if L < `cfg_len`. Otherwise `fifo_clr` pulses, no interrupt is raised and the block waits for sync again.
  - With `cfg_var_len` = 0, the packet has exactly `cfg_len` bytes and no length byte.
- R5: With `cfg_addr_en` = 1, the first byte after the length byte is compared with `cfg_addr`. On a mismatch that byte is not written, `fifo_clr` pulses and no interrupt is raised.
- R6: With `cfg_crc_en` = 1, two CRC bytes follow the payload, high byte first. The CRC uses polynomial 0x1021 with initial value 0xFFFF and no final inversion, computed over every decoded byte from the first byte after sync. On a match, `irq_plready` and `irq_crcok` pulse together.
- R7: If the CRC does not match and `cfg_crc_autoclr` = 1, `fifo_clr` pulses and neither interrupt is raised.
- R8: If the CRC does not match and `cfg_crc_autoclr` = 0, the FIFO keeps the payload and only `irq_plready` pulses.
- R9: With `cfg_crc_en` = 0, `irq_plready` pulses after the last payload byte and `irq_crcok` never pulses.
- R10: A packet opens only when `sync_found` arrives while `rx_en` is high and `fifo_empty` is high. After a packet ends, chips are ignored until the next accepted sync.
- R11: Dropping `rx_en` closes any open packet at once. There are no further writes, clears or interrupts until a new accepted sync.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| sync_found | input | 1 | One-cycle pulse from the sync correlator |
| bit_in | input | 1 | Recovered chip |
| bit_vld | input | 1 | Strobe for `bit_in` |
| cfg_var_len | input | 1 | 1: length byte present; 0: fixed length |
| cfg_len | input | LEN_W | Length limit (variable mode) or payload size (fixed mode) |
| cfg_addr_en | input | 1 | Enable address filtering |
| cfg_addr | input | BYTE_W | Local address |
| cfg_crc_en | input | 1 | Enable CRC checking |
| cfg_crc_autoclr | input | 1 | Clear FIFO on CRC failure |
| cfg_line | input | 2 | Line code select |
| fifo_empty | input | 1 | Receive FIFO empty |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | BYTE_W | FIFO write data |
| fifo_clr | output | 1 | FIFO clear pulse |
| irq_plready | output | 1 | Payload-ready pulse |
| irq_crcok | output | 1 | CRC-good pulse |

## Verification
The bench builds the block with its default parameters: a 7-bit length field, 8-bit bytes, a 16-bit CRC and the whitening variant compiled in. This makes all three line codes and the full CRC residue check reachable from one build. A length limit of 10 puts both sides of the strict comparison in one table: 9 is kept and 10 is rejected. A length byte of zero with address filtering enabled exercises a packet that has no address byte at all. Directed runs cover the following:
- a FIFO that is not empty when sync arrives;
- chips that follow a finished packet;
- receive enable dropped partway through a packet.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEN  = 2'd1,
      ST_BODY = 2'd2,
      ST_CRC  = 2'd3
   } rxd_state_e;

   localparam logic [1:0] LC_PLAIN = 2'd0;
   localparam logic [1:0] LC_MANCH = 2'd1;
   localparam logic [1:0] LC_WHITE = 2'd2;
endpackage

// File: rtl/rxd_linedec.sv
module rxd_linedec #(
   parameter int          WHT_W      = 9,
   parameter int          WHT_TAP    = 5,
   parameter bit          HAS_WHITEN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [1:0] mode,
   input  logic       chip,
   input  logic       chip_vld,
   output logic       dbit,
   output logic       dvld
);
   import rxd_pkg::*;

   logic half_q;
   logic first_q;
   logic wmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q  <= 1'b0;
         first_q <= 1'b0;
      end else if (restart) begin
         half_q  <= 1'b0;
      end else if (chip_vld && mode == LC_MANCH) begin
         half_q <= ~half_q;
         if (!half_q) first_q <= chip;
      end
   end

   generate
      if (HAS_WHITEN) begin : g_wht
         logic [WHT_W-1:0] lfsr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lfsr_q <= '1;
            else if (restart)
               lfsr_q <= '1;
            else if (chip_vld && mode == LC_WHITE)
               lfsr_q <= {lfsr_q[0] ^ lfsr_q[WHT_TAP], lfsr_q[WHT_W-1:1]};
         end
         assign wmask = (mode == LC_WHITE) ? lfsr_q[0] : 1'b0;
      end else begin : g_nowht
         assign wmask = 1'b0;
      end
   endgenerate

   always_comb begin
      dvld = chip_vld && ((mode != LC_MANCH) || half_q);
      dbit = (mode == LC_MANCH) ? first_q : (chip ^ wmask);
   end
endmodule

// File: rtl/rxd_bytepack.sv
module rxd_bytepack #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              dbit,
   input  logic              dvld,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-2:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (dvld) begin
         sh_q  <= {sh_q[BYTE_W-3:0], dbit};
         cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
      end
   end

   always_comb begin
      byte_done = dvld && (cnt_q == CNT_W'(BYTE_W - 1));
      byte_val  = {sh_q, dbit};
   end
endmodule

// File: rtl/rxd_crc.sv
module rxd_crc #(
   parameter int              CRC_W    = 16,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic dbit,
   input  logic dvld,
   output logic resid_zero
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nx;

   always_comb begin
      crc_nx     = {crc_q[CRC_W-2:0], 1'b0} ^ ((crc_q[CRC_W-1] ^ dbit) ? CRC_POLY : '0);
      resid_zero = (crc_nx == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= CRC_INIT;
      else if (restart) crc_q <= CRC_INIT;
      else if (dvld)    crc_q <= crc_nx;
   end
endmodule

// File: rtl/rxd_deframer.sv
module rxd_deframer #(
   parameter int               LEN_W      = 7,
   parameter int               BYTE_W     = 8,
   parameter int               CRC_W      = 16,
   parameter logic [CRC_W-1:0] CRC_POLY   = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT   = 16'hFFFF,
   parameter int               WHT_W      = 9,
   parameter int               WHT_TAP    = 5,
   parameter bit               HAS_WHITEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              sync_found,
   input  logic              bit_in,
   input  logic              bit_vld,
   input  logic              cfg_var_len,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_addr_en,
   input  logic [BYTE_W-1:0] cfg_addr,
   input  logic              cfg_crc_en,
   input  logic              cfg_crc_autoclr,
   input  logic [1:0]        cfg_line,
   input  logic              fifo_empty,
   output logic              fifo_wr,
   output logic [BYTE_W-1:0] fifo_wdata,
   output logic              fifo_clr,
   output logic              irq_plready,
   output logic              irq_crcok
);
   import rxd_pkg::*;

   localparam int CRC_BYTES = CRC_W / BYTE_W;
   localparam int CC_W      = $clog2(CRC_BYTES) + 1;

   if (LEN_W >= BYTE_W) begin : g_bad_len
      $error("LEN_W must be narrower than BYTE_W");
   end
   if ((CRC_W % BYTE_W) != 0) begin : g_bad_crc
      $error("CRC_W must be a whole number of bytes");
   end
   if (WHT_TAP >= WHT_W || WHT_TAP < 1) begin : g_bad_tap
      $error("WHT_TAP must lie inside the whitening register");
   end

   rxd_state_e       state_q;
   logic [LEN_W-1:0] rem_q;
   logic             addr_pend_q;
   logic [CC_W-1:0]  crc_cnt_q;

   logic start, chip_vld, dbit, dvld, byte_done, resid_zero;
   logic len_too_big, crc_last;
   logic [BYTE_W-1:0] byte_val;

   always_comb begin
      start       = (state_q == ST_IDLE) && rx_en && fifo_empty && sync_found;
      chip_vld    = bit_vld && rx_en && (state_q != ST_IDLE);
      len_too_big = byte_val >= {{(BYTE_W-LEN_W){1'b0}}, cfg_len};
      crc_last    = (crc_cnt_q == CC_W'(CRC_BYTES - 1));
   end

   rxd_linedec #(
      .WHT_W(WHT_W), .WHT_TAP(WHT_TAP), .HAS_WHITEN(HAS_WHITEN)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .restart(start), .mode(cfg_line),
      .chip(bit_in), .chip_vld(chip_vld), .dbit(dbit), .dvld(dvld)
   );

   rxd_bytepack #(.BYTE_W(BYTE_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .restart(start), .dbit(dbit), .dvld(dvld),
      .byte_done(byte_done), .byte_val(byte_val)
   );

   rxd_crc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_crc (
      .clk(clk), .rst_n(rst_n), .restart(start), .dbit(dbit), .dvld(dvld),
      .resid_zero(resid_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         rem_q       <= '0;
         addr_pend_q <= 1'b0;
         crc_cnt_q   <= '0;
         fifo_wr     <= 1'b0;
         fifo_wdata  <= '0;
         fifo_clr    <= 1'b0;
         irq_plready <= 1'b0;
         irq_crcok   <= 1'b0;
      end else begin
         fifo_wr     <= 1'b0;
         fifo_clr    <= 1'b0;
         irq_plready <= 1'b0;
         irq_crcok   <= 1'b0;
         if (!rx_en) begin
            state_q <= ST_IDLE;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (start) begin
                     addr_pend_q <= cfg_addr_en;
                     crc_cnt_q   <= '0;
                     rem_q       <= cfg_len;
                     state_q     <= cfg_var_len ? ST_LEN : ST_BODY;
                  end
               end
               ST_LEN: begin
                  if (byte_done) begin
                     if (len_too_big) begin
                        fifo_clr <= 1'b1;
                        state_q  <= ST_IDLE;
                     end else begin
                        fifo_wr    <= 1'b1;
                        fifo_wdata <= byte_val;
                        rem_q      <= byte_val[LEN_W-1:0];
                        state_q    <= ST_BODY;
                     end
                  end
               end
               ST_BODY: begin
                  if (rem_q == '0) begin
                     if (cfg_crc_en) begin
                        state_q <= ST_CRC;
                     end else begin
                        irq_plready <= 1'b1;
                        state_q     <= ST_IDLE;
                     end
                  end else if (byte_done) begin
                     rem_q       <= rem_q - 1'b1;
                     addr_pend_q <= 1'b0;
                     if (addr_pend_q && byte_val != cfg_addr) begin
                        fifo_clr <= 1'b1;
                        state_q  <= ST_IDLE;
                     end else begin
                        fifo_wr    <= 1'b1;
                        fifo_wdata <= byte_val;
                     end
                  end
               end
               ST_CRC: begin
                  if (byte_done) begin
                     if (crc_last) begin
                        state_q <= ST_IDLE;
                        if (resid_zero) begin
                           irq_plready <= 1'b1;
                           irq_crcok   <= 1'b1;
                        end else if (cfg_crc_autoclr) begin
                           fifo_clr <= 1'b1;
                        end else begin
                           irq_plready <= 1'b1;
                        end
                     end else begin
                        crc_cnt_q <= crc_cnt_q + 1'b1;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rxd_deframer_chk.sv
module rxd_deframer_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_en,
   input logic cfg_crc_en,
   input logic fifo_wr,
   input logic fifo_clr,
   input logic irq_plready,
   input logic irq_crcok
);
   // R2
   wr_vs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> !fifo_clr);

   // R7
   clr_vs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |-> !irq_plready);

   // R6
   crcok_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_crcok |-> irq_plready);

   // R9
   crcok_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_crcok |-> $past(cfg_crc_en));

   // R11
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!fifo_wr && !fifo_clr && !irq_plready));
endmodule

bind rxd_deframer rxd_deframer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_crc_en(cfg_crc_en),
   .fifo_wr(fifo_wr), .fifo_clr(fifo_clr), .irq_plready(irq_plready),
   .irq_crcok(irq_crcok)
);

// File: tb/sim_rxd_deframer.sv
module sim_rxd_deframer;
   localparam logic [7:0] MY_ADDR = 8'hC5;
   localparam int NV = 13;
   // fields: var, addr_en, crc_en, autoclr, line[2], len_cfg[7], nb[7], addr_ok, bad_crc | pl, ok, clr, cnt[8]
   localparam logic [32:0] VEC [0:NV-1] = '{
      {1'b1,1'b0,1'b1,1'b1,2'd0,7'd20,7'd5, 1'b1,1'b0, 1'b1,1'b1,1'b0,8'd6},
      {1'b1,1'b1,1'b1,1'b1,2'd1,7'd20,7'd4, 1'b1,1'b0, 1'b1,1'b1,1'b0,8'd5},
      {1'b1,1'b1,1'b1,1'b1,2'd2,7'd20,7'd6, 1'b1,1'b0, 1'b1,1'b1,1'b0,8'd7},
      {1'b0,1'b0,1'b1,1'b1,2'd0,7'd3, 7'd0, 1'b1,1'b0, 1'b1,1'b1,1'b0,8'd3},
      {1'b1,1'b0,1'b1,1'b1,2'd0,7'd10,7'd10,1'b1,1'b0, 1'b0,1'b0,1'b1,8'd0},
      {1'b1,1'b0,1'b1,1'b1,2'd0,7'd10,7'd9, 1'b1,1'b0, 1'b1,1'b1,1'b0,8'd10},
      {1'b1,1'b1,1'b1,1'b1,2'd0,7'd20,7'd3, 1'b0,1'b0, 1'b0,1'b0,1'b1,8'd0},
      {1'b1,1'b0,1'b1,1'b1,2'd0,7'd20,7'd3, 1'b1,1'b1, 1'b0,1'b0,1'b1,8'd0},
      {1'b1,1'b0,1'b1,1'b0,2'd0,7'd20,7'd3, 1'b1,1'b1, 1'b1,1'b0,1'b0,8'd4},
      {1'b1,1'b0,1'b0,1'b1,2'd0,7'd20,7'd2, 1'b1,1'b0, 1'b1,1'b0,1'b0,8'd3},
      {1'b0,1'b1,1'b0,1'b1,2'd1,7'd4, 7'd0, 1'b1,1'b0, 1'b1,1'b0,1'b0,8'd4},
      {1'b1,1'b1,1'b1,1'b1,2'd2,7'd20,7'd0, 1'b1,1'b0, 1'b1,1'b1,1'b0,8'd1},
      {1'b1,1'b0,1'b1,1'b0,2'd2,7'd20,7'd5, 1'b1,1'b1, 1'b1,1'b0,1'b0,8'd6}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_en = 1'b1;
   logic sync_found = 1'b0;
   logic bit_in = 1'b0;
   logic bit_vld = 1'b0;
   logic cfg_var_len = 1'b1;
   logic [6:0] cfg_len = 7'd20;
   logic cfg_addr_en = 1'b0;
   logic [7:0] cfg_addr = MY_ADDR;
   logic cfg_crc_en = 1'b1;
   logic cfg_crc_autoclr = 1'b1;
   logic [1:0] cfg_line = 2'd0;
   logic fifo_empty;
   logic fifo_wr, fifo_clr, irq_plready, irq_crcok;
   logic [7:0] fifo_wdata;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int qn = 0;
   logic [7:0] q [0:255];
   int clr_seen = 0, pl_seen = 0, ok_seen = 0;
   logic [7:0] pkt [0:63];
   int plen = 0, tot = 0;
   int chip_idx = 0, abort_at = -1;

   always #10 clk = ~clk;
   assign fifo_empty = (qn == 0);

   rxd_deframer u0 (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sync_found(sync_found),
      .bit_in(bit_in), .bit_vld(bit_vld), .cfg_var_len(cfg_var_len),
      .cfg_len(cfg_len), .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr),
      .cfg_crc_en(cfg_crc_en), .cfg_crc_autoclr(cfg_crc_autoclr),
      .cfg_line(cfg_line), .fifo_empty(fifo_empty), .fifo_wr(fifo_wr),
      .fifo_wdata(fifo_wdata), .fifo_clr(fifo_clr),
      .irq_plready(irq_plready), .irq_crcok(irq_crcok)
   );

   // host-side FIFO model and interrupt counters
   always @(negedge clk) begin
      cycles = cycles + 1;
      if (fifo_clr) begin qn = 0; clr_seen = clr_seen + 1; end
      if (fifo_wr) begin q[qn] = fifo_wdata; qn = qn + 1; end
      if (irq_plready) pl_seen = pl_seen + 1;
      if (irq_crcok) ok_seen = ok_seen + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish, act=%0d cycles exp<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int k = 7; k >= 0; k--) begin
         logic fb = r[15] ^ b[k];
         r = {r[14:0], 1'b0};
         if (fb) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   task automatic build(input bit v, input bit ae, input bit ce, input int nb,
                        input bit aok, input bit bad, input int lencfg);
      int n = v ? nb : lencfg;
      int k = 0;
      logic [15:0] c = 16'hFFFF;
      if (v) begin pkt[k] = 8'(nb); k++; end
      for (int i = 0; i < n; i++) begin
         if (ae && i == 0) pkt[k] = aok ? MY_ADDR : (MY_ADDR ^ 8'h5A);
         else pkt[k] = 8'h3C + 8'(i * 7);
         k++;
      end
      plen = k;
      if (ce) begin
         for (int j = 0; j < plen; j++) c = crc_byte(c, pkt[j]);
         if (bad) c = c ^ 16'h0001;
         pkt[k] = c[15:8]; k++;
         pkt[k] = c[7:0];  k++;
      end
      tot = k;
   endtask

   task automatic chip(input logic b);
      if (chip_idx == abort_at) begin
         @(negedge clk); rx_en = 1'b0;
         @(negedge clk);
         @(negedge clk); rx_en = 1'b1;
      end
      @(negedge clk); bit_in = b; bit_vld = 1'b1;
      @(negedge clk); bit_vld = 1'b0;
      chip_idx++;
   endtask

   task automatic send_pkt(input logic [1:0] line, input bit do_sync);
      logic [8:0] w = 9'h1FF;
      for (int i = 0; i < 16; i++) chip(i[0]);   // preamble, dropped (R1)
      if (do_sync) begin
         @(negedge clk); sync_found = 1'b1; bit_in = 1'b1; bit_vld = 1'b1;
         @(negedge clk); sync_found = 1'b0; bit_vld = 1'b0;
      end
      chip_idx = 0;
      for (int j = 0; j < tot; j++) begin
         for (int b = 7; b >= 0; b--) begin
            logic d = pkt[j][b];
            case (line)
               2'd1: begin chip(d); chip(~d); end
               2'd2: begin chip(d ^ w[0]); w = {w[0] ^ w[5], w[8:1]}; end
               default: chip(d);
            endcase
         end
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic clear_counts();
      @(negedge clk);
      qn = 0; clr_seen = 0; pl_seen = 0; ok_seen = 0;
   endtask

   function automatic string vec_req(input int i);
      case (i)
         0: return "R2";   1: return "R3";   2: return "R3";   3: return "R4";
         4: return "R4";   5: return "R4";   6: return "R5";   7: return "R7";
         8: return "R8";   9: return "R9";   10: return "R3";  11: return "R6";
         default: return "R8";
      endcase
   endfunction

   initial begin
      // R12: outputs quiet in and after reset
      repeat (3) @(negedge clk);
      chk(!fifo_wr && !fifo_clr && !irq_plready && !irq_crcok, "R12 reset",
          {fifo_wr, fifo_clr, irq_plready, irq_crcok}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!fifo_wr && !fifo_clr && !irq_plready && !irq_crcok, "R12 after reset",
          {fifo_wr, fifo_clr, irq_plready, irq_crcok}, 0);

      // table-driven packets
      for (int i = 0; i < NV; i++) begin
         logic [32:0] v = VEC[i];
         int mism = 0;
         clear_counts();
         cfg_var_len = v[32]; cfg_addr_en = v[31]; cfg_crc_en = v[30];
         cfg_crc_autoclr = v[29]; cfg_line = v[28:27]; cfg_len = v[26:20];
         build(v[32], v[31], v[30], int'(v[19:13]), v[12], v[11], int'(v[26:20]));
         abort_at = -1;
         send_pkt(v[28:27], 1'b1);
         chk(pl_seen == int'(v[10]), {vec_req(i), " payload-ready"}, pl_seen, int'(v[10]));
         chk(ok_seen == int'(v[9]), {vec_req(i), " crc-ok"}, ok_seen, int'(v[9]));
         chk((clr_seen != 0) == v[8], {vec_req(i), " clear"}, clr_seen, int'(v[8]));
         chk(qn == int'(v[7:0]), {vec_req(i), " fifo count"}, qn, int'(v[7:0]));
         for (int k = 0; k < qn && k < int'(v[7:0]); k++)
            if (q[k] != pkt[k]) mism++;
         chk(mism == 0, {vec_req(i), " fifo data"}, mism, 0);
      end

      // R1: chips without sync never reach the FIFO
      clear_counts();
      cfg_var_len = 1'b1; cfg_addr_en = 1'b0; cfg_crc_en = 1'b1; cfg_line = 2'd0;
      cfg_len = 7'd20; cfg_crc_autoclr = 1'b1;
      build(1'b1, 1'b0, 1'b1, 3, 1'b1, 1'b0, 20);
      send_pkt(2'd0, 1'b0);
      chk(qn == 0 && pl_seen == 0, "R1 no sync", qn + pl_seen, 0);

      // R10: sync ignored while FIFO holds data
      clear_counts();
      q[0] = 8'h99; qn = 1;
      send_pkt(2'd0, 1'b1);
      chk(qn == 1 && q[0] == 8'h99, "R10 fifo not empty", qn, 1);
      chk(pl_seen == 0, "R10 no irq when blocked", pl_seen, 0);

      // R10: after a finished packet, trailing chips are ignored
      clear_counts();
      send_pkt(2'd0, 1'b1);
      chk(pl_seen == 1 && qn == 4, "R10 good packet", qn, 4);
      for (int i = 0; i < 24; i++) chip(1'b1);
      repeat (4) @(negedge clk);
      chk(qn == 4 && pl_seen == 1, "R10 trailing chips", qn, 4);

      // R11: receive enable dropped mid-packet
      clear_counts();
      abort_at = 12;
      send_pkt(2'd0, 1'b1);
      abort_at = -1;
      chk(qn == 1, "R11 abort fifo count", qn, 1);
      chk(pl_seen == 0 && clr_seen == 0, "R11 abort quiet", pl_seen + clr_seen, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule